// File: doc/BRIEF.md
# Execution Unit Assignment Controller

This block hands out a pool of execution units to a set of channels at run time. A channel names the unit it wants and says whether it wants that unit as its primary or as its secondary. The controller grants the unit once nobody owns it, and the channel keeps the grant until it drops all of its units with a single release pulse. A channel that needs two units gets each one as soon as that unit is free. It never waits for both units to be idle at once.

After a channel holds both a primary and a secondary unit, it may ask for its secondary unit to watch the bus in either the inbound or the outbound direction. The controller records each direction in a status bit for that channel. When several channels want the same idle unit in the same cycle, a round-robin pointer kept for each unit picks the winner. The channel count is a parameter and may be 1, 2 or 4. Assignment stays dynamic even when there is only one channel.

Top module: `eu_assign_ctrl`

## Requirements
- R1: While reset is low, and on the first clock edge after it, every grant, every busy flag and every snoop status bit reads 0.
- R2: A primary request (req_sec=0) for a unit that no channel owns sets pri_gnt of that channel at the next rising edge, and pri_eu shows the unit index. The index for channel c sits in bits [2c+1:2c] of req_eu, pri_eu and sec_eu. Requests from several channels for different idle units are all served in the same edge.
- R3: A grant stays set until its channel pulses rel. The edge that samples rel clears both grants and both snoop bits of that channel. A request for the freed unit made in that same cycle is not served.
- R4: A secondary request (req_sec=1) is ignored unless the channel already holds a primary grant. A request for a unit the channel itself holds is never granted. sec_gnt is never set without pri_gnt.
- R5: A primary grant is given even while the unit the channel will later want as secondary is owned elsewhere.
- R6: A request for a unit owned by another channel raises no flag and stays unserved. If the request is still held, it is granted at the first edge that samples the unit as unowned.
- R7: snp_req is accepted only at an edge where the channel holds both grants. snp_out_sel=0 sets snp_in_st and snp_out_sel=1 sets snp_out_st. Both bits stay set until release.
- R8: Each unit has a pointer that starts at channel 0. Competing channels are searched upward from the pointer, wrapping around. After a grant of that unit, the pointer moves to the winner plus one.
- R9: A unit is owned by at most one grant at a time. eu_busy[e] is 1 exactly while unit e is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | NCH | Request valid, one bit per channel |
| req_sec | input | NCH | 1 = secondary request, 0 = primary |
| req_eu | input | NCH*EW | Requested unit index per channel |
| rel | input | NCH | Release all units of the channel |
| snp_req | input | NCH | Snoop request for the secondary unit |
| snp_out_sel | input | NCH | Snoop direction: 0 inbound, 1 outbound |
| pri_gnt | output | NCH | Primary grant held |
| sec_gnt | output | NCH | Secondary grant held |
| pri_eu | output | NCH*EW | Unit index of the primary grant |
| sec_eu | output | NCH*EW | Unit index of the secondary grant |
| eu_busy | output | NEU | Unit currently owned |
| snp_in_st | output | NCH | Inbound snooping active |
| snp_out_st | output | NCH | Outbound snooping active |

## Verification
The assertions check several rules on every cycle:
- grants persist until release;
- a release clears all state of the channel;
- a secondary grant never exists without a primary one;
- a snoop bit rises only while both grants are held;
- the busy count always equals the number of grants held.

Some behaviours can only be shown by the bench's scenarios. These are which channel wins a contested unit over successive rounds, how long a request for an owned unit stays pending, and the one-cycle gap after a release before the unit can be granted again. The bench also shows that a primary grant arrives while the intended secondary unit is still busy.

// File: rtl/eu_assign_ctrl.sv
module eu_assign_ctrl #(
  parameter int NCH = 4,
  parameter int NEU = 4,
  localparam int EW = (NEU > 1) ? $clog2(NEU) : 1,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_vld,
  input  logic [NCH-1:0]    req_sec,
  input  logic [NCH*EW-1:0] req_eu,
  input  logic [NCH-1:0]    rel,
  input  logic [NCH-1:0]    snp_req,
  input  logic [NCH-1:0]    snp_out_sel,
  output logic [NCH-1:0]    pri_gnt,
  output logic [NCH-1:0]    sec_gnt,
  output logic [NCH*EW-1:0] pri_eu,
  output logic [NCH*EW-1:0] sec_eu,
  output logic [NEU-1:0]    eu_busy,
  output logic [NCH-1:0]    snp_in_st,
  output logic [NCH-1:0]    snp_out_st
);

  logic [NCH-1:0] pri_v, sec_v, sn_i, sn_o, elig, take_v;
  logic [EW-1:0]  pri_i [NCH];
  logic [EW-1:0]  sec_i [NCH];
  logic [EW-1:0]  take_e [NCH];
  logic [CW-1:0]  rr [NEU];
  logic [CW-1:0]  win_c [NEU];
  logic [NEU-1:0] owned, win_v;

  always_comb begin
    owned = '0;
    for (int e = 0; e < NEU; e++)
      for (int c = 0; c < NCH; c++)
        if ((pri_v[c] && pri_i[c] == EW'(e)) || (sec_v[c] && sec_i[c] == EW'(e)))
          owned[e] = 1'b1;
  end

  always_comb
    for (int c = 0; c < NCH; c++)
      elig[c] = req_vld[c] && !rel[c] && (req_sec[c] ? (pri_v[c] && !sec_v[c]) : !pri_v[c]);

  always_comb begin
    for (int e = 0; e < NEU; e++) begin
      win_v[e] = 1'b0;
      win_c[e] = '0;
      for (int k = 0; k < NCH; k++) begin
        int idx;
        idx = (int'(rr[e]) + k) % NCH;
        if (!win_v[e] && !owned[e] && elig[idx] && req_eu[idx*EW +: EW] == EW'(e)) begin
          win_v[e] = 1'b1;
          win_c[e] = CW'(idx);
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      take_v[c] = 1'b0;
      take_e[c] = '0;
      for (int e = 0; e < NEU; e++)
        if (win_v[e] && win_c[e] == CW'(c)) begin
          take_v[c] = 1'b1;
          take_e[c] = EW'(e);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_v <= '0;
      sec_v <= '0;
      sn_i  <= '0;
      sn_o  <= '0;
      for (int c = 0; c < NCH; c++) begin
        pri_i[c] <= '0;
        sec_i[c] <= '0;
      end
      for (int e = 0; e < NEU; e++) rr[e] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (rel[c]) begin
          pri_v[c] <= 1'b0;
          sec_v[c] <= 1'b0;
          sn_i[c]  <= 1'b0;
          sn_o[c]  <= 1'b0;
        end else begin
          if (take_v[c] && req_sec[c]) begin
            sec_v[c] <= 1'b1;
            sec_i[c] <= take_e[c];
          end else if (take_v[c]) begin
            pri_v[c] <= 1'b1;
            pri_i[c] <= take_e[c];
          end
          if (snp_req[c] && pri_v[c] && sec_v[c]) begin
            if (snp_out_sel[c]) sn_o[c] <= 1'b1;
            else                sn_i[c] <= 1'b1;
          end
        end
      end
      for (int e = 0; e < NEU; e++)
        if (win_v[e]) rr[e] <= CW'((int'(win_c[e]) + 1) % NCH);
    end
  end

  assign pri_gnt    = pri_v;
  assign sec_gnt    = sec_v;
  assign snp_in_st  = sn_i;
  assign snp_out_st = sn_o;
  assign eu_busy    = owned;

  for (genvar c = 0; c < NCH; c++) begin : g_idx
    assign pri_eu[c*EW +: EW] = pri_i[c];
    assign sec_eu[c*EW +: EW] = sec_i[c];
  end

endmodule

// File: rtl/eu_assign_ctrl_chk.sv
module eu_assign_ctrl_chk #(
  parameter int NCH = 4,
  parameter int NEU = 4,
  localparam int EW = (NEU > 1) ? $clog2(NEU) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    req_vld,
  input logic [NCH-1:0]    req_sec,
  input logic [NCH*EW-1:0] req_eu,
  input logic [NCH-1:0]    rel,
  input logic [NCH-1:0]    snp_req,
  input logic [NCH-1:0]    snp_out_sel,
  input logic [NCH-1:0]    pri_gnt,
  input logic [NCH-1:0]    sec_gnt,
  input logic [NCH*EW-1:0] pri_eu,
  input logic [NCH*EW-1:0] sec_eu,
  input logic [NEU-1:0]    eu_busy,
  input logic [NCH-1:0]    snp_in_st,
  input logic [NCH-1:0]    snp_out_st
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_pri_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pri_gnt[c] && !rel[c] |=> pri_gnt[c] && $stable(pri_eu[c*EW +: EW]));
    assert_sec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_gnt[c] && !rel[c] |=> sec_gnt[c]);
    assert_release_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rel[c] |=> !pri_gnt[c] && !sec_gnt[c] && !snp_in_st[c] && !snp_out_st[c]);
    assert_sec_needs_pri_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_gnt[c] |-> pri_gnt[c]);
    assert_snoop_in_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snp_in_st[c]) |-> $past(pri_gnt[c] && sec_gnt[c] && snp_req[c] && !snp_out_sel[c]));
    assert_snoop_out_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snp_out_st[c]) |-> $past(pri_gnt[c] && sec_gnt[c] && snp_req[c] && snp_out_sel[c]));
  end

  assert_unique_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(eu_busy) == $countones(pri_gnt) + $countones(sec_gnt));

endmodule

bind eu_assign_ctrl eu_assign_ctrl_chk #(.NCH(NCH), .NEU(NEU)) u_chk (.*);

// File: tb/eu_assign_ctrl_tb.sv
module eu_assign_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NEU = 4;
  localparam int NV  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req_vld = '0, req_sec = '0, rel = '0, snp_req = '0, snp_out_sel = '0;
  logic [7:0] req_eu = '0;
  logic [3:0] pri_gnt, sec_gnt, eu_busy, snp_in_st, snp_out_st;
  logic [7:0] pri_eu, sec_eu;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eu_assign_ctrl #(.NCH(NCH), .NEU(NEU)) u_dut (.*);

  // {req, vld, sec, eu, rel, snp, sout, e_pri, e_sec, e_busy, e_sni, e_sno}
  localparam logic [51:0] VEC [NV] = '{
    {4'd1, 4'b0000, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R1 idle
    {4'd2, 4'b0001, 4'b0000, 8'b00000010, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R2
    {4'd4, 4'b0001, 4'b0001, 8'b00000010, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R4 own unit
    {4'd4, 4'b0010, 4'b0010, 8'b00000100, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R4 no primary
    {4'd6, 4'b0010, 4'b0000, 8'b00001000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R6 pending
    {4'd7, 4'b0000, 4'b0000, 8'b00000000, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R7 rejected
    {4'd2, 4'b0011, 4'b0001, 8'b00001011, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b1100, 4'b0000, 4'b0000}, // R2 secondary
    {4'd7, 4'b0000, 4'b0000, 8'b00000000, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b1100, 4'b0001, 4'b0000}, // R7 in
    {4'd7, 4'b0000, 4'b0000, 8'b00000000, 4'b0000, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b1100, 4'b0001, 4'b0001}, // R7 out
    {4'd3, 4'b0010, 4'b0000, 8'b00001000, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R3 release
    {4'd6, 4'b0010, 4'b0000, 8'b00001000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R6 served
    {4'd8, 4'b1100, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0000, 4'b0101, 4'b0000, 4'b0000}, // R8 ch2 wins
    {4'd6, 4'b1000, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0000, 4'b0101, 4'b0000, 4'b0000}, // R6
    {4'd3, 4'b1000, 4'b0000, 8'b00000000, 4'b0100, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R3 gap
    {4'd6, 4'b1000, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b1010, 4'b0000, 4'b0101, 4'b0000, 4'b0000}, // R6
    {4'd3, 4'b0000, 4'b0000, 8'b00000000, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R3
    {4'd8, 4'b1010, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0001, 4'b0000, 4'b0000}, // R8 ch1
    {4'd3, 4'b0000, 4'b0000, 8'b00000000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R3
    {4'd8, 4'b1010, 4'b0000, 8'b00000000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 4'b0000, 4'b0001, 4'b0000, 4'b0000}, // R8 ch3
    {4'd2, 4'b0111, 4'b0000, 8'b00111001, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000}  // R2 parallel
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] v, input logic [3:0] s, input logic [7:0] e,
                      input logic [3:0] r, input logic [3:0] sn, input logic [3:0] so);
    req_vld = v; req_sec = s; req_eu = e; rel = r; snp_req = sn; snp_out_sel = so;
    @(negedge clk);
  endtask

  function automatic logic [19:0] outs();
    return {pri_gnt, sec_gnt, eu_busy, snp_in_st, snp_out_st};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {12'd0, outs()}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {12'd0, outs()}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][47:44], VEC[i][43:40], VEC[i][39:32], VEC[i][31:28], VEC[i][27:24], VEC[i][23:20]);
      check($sformatf("R%0d vector %0d", VEC[i][51:48], i), {12'd0, outs()}, {12'd0, VEC[i][19:0]});
    end

    // R2 indices: ch3=0 ch2=3 ch1=2 ch0=1
    check("R2 pri_eu", {24'd0, pri_eu}, 32'h39);

    // R5: ch1 takes primary 2 while its wanted secondary 3 is held by ch2
    step(4'b0000, 4'b0000, 8'h00, 4'b0010, 4'b0000, 4'b0000);
    check("R3 free unit 2", {28'd0, eu_busy}, 32'b1011);
    step(4'b0010, 4'b0000, 8'b00001000, 4'b0000, 4'b0000, 4'b0000);
    check("R5 primary granted", {28'd0, pri_gnt}, 32'b1111);
    step(4'b0010, 4'b0010, 8'b00001100, 4'b0000, 4'b0000, 4'b0000);
    check("R6 secondary pending", {28'd0, sec_gnt}, 32'b0000);
    step(4'b0010, 4'b0010, 8'b00001100, 4'b0100, 4'b0000, 4'b0000);
    check("R3 no grant in release cycle", {28'd0, sec_gnt}, 32'b0000);
    step(4'b0010, 4'b0010, 8'b00001100, 4'b0000, 4'b0000, 4'b0000);
    check("R6 secondary granted", {28'd0, sec_gnt}, 32'b0010);
    check("R5 sec_eu", {30'd0, sec_eu[3:2]}, 32'd3);
    check("R9 busy", {28'd0, eu_busy}, 32'b1111);
    step(4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {12'd0, outs()}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule